// File: doc/BRIEF.md
# Telemetry Frame Commutator

This block builds an engineering telemetry stream out of one-byte parameters. A format table holds one source address for each byte slot of a minor frame. Software can rewrite the table while the stream runs. On each fast tick the block walks the next group of slots. It reads each parameter through a simple read port with one cycle of latency and emits the bytes in slot order on a byte stream. The parameters can be hardware readings or software variables mapped into the read port's address space.

Minor frames are a fixed number of ticks long. A fixed number of minor frames makes one major frame. The stream marks the first byte of every minor frame and of every major frame, and it carries the index of the current minor frame. Three output rates are available. The lower rates emit a burst only on every 2^k-th tick of a minor frame, counted from the frame's first tick. The minor frame period therefore stays the same at every rate, while the byte count per frame shrinks. A table edit is applied at the next minor frame boundary. A rate request is applied at the next major frame boundary.

Top module: `tlm_commutator`

## Requirements
- R1: While reset is held and after it is released, `byte_valid_o`, `rd_en_o`, `minor_sop_o` and `major_sop_o` are low and `minor_idx_o` is 0. Nothing is emitted until the first `tick_i`.
- R2: An enabled tick produces `BPT` bytes from consecutive slots. Slots are numbered from 0 at the start of each minor frame. Each byte equals the value returned by the read port for the address held in that slot's table entry. No byte appears without a tick.
- R3: Rate code 2 (high) enables every tick. Code 1 (standard) enables ticks whose position in the minor frame is a multiple of 2^`STD_SHIFT`. Code 0 (safing) enables positions that are multiples of 2^`SAFE_SHIFT`. The byte count of a minor frame is `BPT` times the number of enabled ticks.
- R4: `minor_sop_o` is high only together with the first byte of a minor frame. `major_sop_o` is high only together with the first byte of minor frame 0. Both are high only while `byte_valid_o` is high.
- R5: `minor_idx_o` steps by one on the first tick of each minor frame and wraps from `MPM`-1 to 0.
- R6: A table write made during a minor frame has no effect on that frame's read addresses. It applies from the first tick of the next minor frame.
- R7: `rate_req_i` is sampled only on the first tick of minor frame 0. The rate in use never changes at any other time.
- R8: Rate code 3 is reserved. If it is present at a major boundary, the previous rate is kept.
- R9: `rd_en_o` is high for exactly `BPT` consecutive cycles after each enabled tick, starting the cycle after the tick, and at no other time.
- R10: At every rate, consecutive minor frame starts are exactly `TPM` ticks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle fast tick pulse, spaced at least BPT+3 cycles apart |
| rate_req_i | input | 2 | Requested rate: 0 safing, 1 standard, 2 high, 3 reserved |
| tw_en_i | input | 1 | Table write strobe |
| tw_idx_i | input | SLOT_W | Slot index to write |
| tw_src_i | input | AW | Source address stored for that slot |
| rd_en_o | output | 1 | Parameter read request |
| rd_addr_o | output | AW | Parameter source address |
| rd_data_i | input | 8 | Parameter byte, valid the cycle after rd_en_o |
| byte_valid_o | output | 1 | Output byte strobe |
| byte_o | output | 8 | Output telemetry byte |
| minor_sop_o | output | 1 | First byte of a minor frame |
| major_sop_o | output | 1 | First byte of a major frame |
| minor_idx_o | output | MN_W | Current minor frame index |

## Verification
The embedded assertions check on every cycle that the rate register only ever holds a legal code and changes only at a major boundary. They also check that each read burst starts right after a tick, that frame markers never appear without a byte, and that the minor index only steps by one or wraps to zero. The bench's scenarios are needed to show the things the assertions cannot: the byte values, the table lookups, the per-frame byte counts, and the boundary at which a table edit or a rate change actually takes effect. For these it compares the stream against an arithmetic model of the frame walk across a full sweep of rates on a small configuration.

// File: rtl/tlm_pkg.sv
package tlm_pkg;

    typedef enum logic [1:0] {
        RATE_SAFE = 2'd0,
        RATE_STD  = 2'd1,
        RATE_HIGH = 2'd2,
        RATE_RSVD = 2'd3
    } rate_e;

    typedef struct packed {
        logic minor_sop;
        logic major_sop;
    } mark_t;

    // Mask of tick-position bits that must be zero for a tick to emit a burst
    function automatic logic [15:0] tick_mask(rate_e r, int unsigned sh_std, int unsigned sh_safe);
        case (r)
            RATE_STD:  return 16'((1 << sh_std) - 1);
            RATE_SAFE: return 16'((1 << sh_safe) - 1);
            default:   return 16'd0;
        endcase
    endfunction

endpackage

// File: rtl/tlm_fmt_table.sv
module tlm_fmt_table #(
    parameter int SLOTS  = 200,
    parameter int SLOT_W = 8,
    parameter int AW     = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [SLOT_W-1:0] wr_idx_i,
    input  logic [AW-1:0]     wr_src_i,
    input  logic              commit_i,
    input  logic [SLOT_W-1:0] rd_idx_i,
    output logic [AW-1:0]     rd_src_o
);

    logic [AW-1:0] act_vec [SLOTS];

    // Each slot has a staging copy written by software and a live copy used by the walk
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [AW-1:0] stage_q;
        logic [AW-1:0] live_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q <= '0;
                live_q  <= '0;
            end else begin
                if (wr_en_i && wr_idx_i == SLOT_W'(g)) stage_q <= wr_src_i;
                if (commit_i) live_q <= stage_q;
            end
        end
        assign act_vec[g] = live_q;
    end

    always_comb begin
        rd_src_o = '0;
        if (32'(rd_idx_i) < SLOTS) rd_src_o = act_vec[rd_idx_i];
    end

endmodule

// File: rtl/tlm_frame_seq.sv
module tlm_frame_seq
    import tlm_pkg::*;
#(
    parameter int TPM        = 50,
    parameter int BPT        = 4,
    parameter int MPM        = 1200,
    parameter int STD_SHIFT  = 3,
    parameter int SAFE_SHIFT = 6,
    parameter int SLOT_W     = 8,
    parameter int MN_W       = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [1:0]        rate_req_i,
    output logic              commit_o,
    output logic              req_valid_o,
    output logic [SLOT_W-1:0] slot_o,
    output mark_t             mark_o,
    output logic [MN_W-1:0]   minor_idx_o
);

    localparam int TP_W = (TPM > 1) ? $clog2(TPM) : 1;
    localparam int BC_W = (BPT > 1) ? $clog2(BPT) : 1;

    logic [TP_W-1:0]   tp_q;
    logic [MN_W-1:0]   minor_next_q, minor_cur_q;
    rate_e             rate_q, rate_nxt;
    logic              busy_q;
    logic [BC_W-1:0]   beat_q;
    logic [SLOT_W-1:0] slot_q, base_q, base_cur;
    mark_t             mark_q;
    logic              at_minor, at_major, fire;

    always_comb begin
        at_minor = tick_i && (tp_q == '0);
        at_major = at_minor && (minor_next_q == '0);
        rate_nxt = rate_q;
        if (at_major && rate_req_i != RATE_RSVD) rate_nxt = rate_e'(rate_req_i);
        fire     = tick_i && ((16'(tp_q) & tick_mask(rate_nxt, STD_SHIFT, SAFE_SHIFT)) == 16'd0);
        base_cur = at_minor ? '0 : base_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tp_q         <= '0;
            minor_next_q <= '0;
            minor_cur_q  <= '0;
            rate_q       <= RATE_HIGH;
            busy_q       <= 1'b0;
            beat_q       <= '0;
            slot_q       <= '0;
            base_q       <= '0;
            mark_q       <= '0;
        end else begin
            if (tick_i) begin
                if (tp_q == TP_W'(TPM - 1)) begin
                    tp_q         <= '0;
                    minor_next_q <= (minor_next_q == MN_W'(MPM - 1)) ? '0 : minor_next_q + 1'b1;
                end else begin
                    tp_q <= tp_q + 1'b1;
                end
            end
            if (at_minor) minor_cur_q <= minor_next_q;
            rate_q <= rate_nxt;
            if (fire) begin
                busy_q <= 1'b1;
                beat_q <= '0;
                slot_q <= base_cur;
                base_q <= base_cur + SLOT_W'(BPT);
                mark_q <= '{minor_sop: at_minor, major_sop: at_major};
            end else if (busy_q) begin
                mark_q <= '0;
                slot_q <= slot_q + 1'b1;
                if (beat_q == BC_W'(BPT - 1)) busy_q <= 1'b0;
                else beat_q <= beat_q + 1'b1;
            end
        end
    end

    assign commit_o    = at_minor;
    assign req_valid_o = busy_q;
    assign slot_o      = slot_q;
    assign mark_o      = mark_q;
    assign minor_idx_o = minor_cur_q;

    AST_RATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        rate_q != RATE_RSVD); // R8
    AST_RATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(tick_i && tp_q == '0 && minor_next_q == '0) |=> $stable(rate_q)); // R7
    AST_BURST_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(tick_i)); // R9
    AST_MINOR_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(minor_cur_q) < MPM); // R5
    AST_TICK_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
        32'(tp_q) < TPM); // R10

endmodule

// File: rtl/tlm_byte_out.sv
module tlm_byte_out
    import tlm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid_i,
    input  mark_t         mark_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          byte_valid_o,
    output logic [DW-1:0] byte_o,
    output mark_t         mark_o
);

    logic  v1_q;
    mark_t m1_q;

    // Stage 1 waits out the read latency, stage 2 registers the returned byte
    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q         <= 1'b0;
            m1_q         <= '0;
            byte_valid_o <= 1'b0;
            byte_o       <= '0;
            mark_o       <= '0;
        end else begin
            v1_q         <= req_valid_i;
            m1_q         <= req_valid_i ? mark_i : '0;
            byte_valid_o <= v1_q;
            byte_o       <= v1_q ? rd_data_i : '0;
            mark_o       <= v1_q ? m1_q : '0;
        end
    end

    AST_MARK_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
        (mark_o.minor_sop || mark_o.major_sop) |-> byte_valid_o); // R4
    AST_MAJOR_IMPLIES_MINOR: assert property (@(posedge clk) disable iff (rst)
        mark_o.major_sop |-> mark_o.minor_sop); // R4

endmodule

// File: rtl/tlm_commutator.sv
module tlm_commutator
    import tlm_pkg::*;
#(
    parameter int TPM        = 50,
    parameter int BPT        = 4,
    parameter int MPM        = 1200,
    parameter int STD_SHIFT  = 3,
    parameter int SAFE_SHIFT = 6,
    parameter int AW         = 10,
    localparam int SLOTS     = TPM * BPT,
    localparam int SLOT_W    = $clog2(SLOTS + 1),
    localparam int MN_W      = (MPM > 1) ? $clog2(MPM) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic [1:0]        rate_req_i,
    input  logic              tw_en_i,
    input  logic [SLOT_W-1:0] tw_idx_i,
    input  logic [AW-1:0]     tw_src_i,
    output logic              rd_en_o,
    output logic [AW-1:0]     rd_addr_o,
    input  logic [7:0]        rd_data_i,
    output logic              byte_valid_o,
    output logic [7:0]        byte_o,
    output logic              minor_sop_o,
    output logic              major_sop_o,
    output logic [MN_W-1:0]   minor_idx_o
);

    logic              commit;
    logic              req_valid;
    logic [SLOT_W-1:0] slot;
    mark_t             req_mark, out_mark;

    tlm_frame_seq #(
        .TPM(TPM), .BPT(BPT), .MPM(MPM), .STD_SHIFT(STD_SHIFT),
        .SAFE_SHIFT(SAFE_SHIFT), .SLOT_W(SLOT_W), .MN_W(MN_W)
    ) u_seq (
        .clk(clk), .rst(rst), .tick_i(tick_i), .rate_req_i(rate_req_i),
        .commit_o(commit), .req_valid_o(req_valid), .slot_o(slot),
        .mark_o(req_mark), .minor_idx_o(minor_idx_o)
    );

    tlm_fmt_table #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .AW(AW)) u_tab (
        .clk(clk), .rst(rst), .wr_en_i(tw_en_i), .wr_idx_i(tw_idx_i),
        .wr_src_i(tw_src_i), .commit_i(commit), .rd_idx_i(slot), .rd_src_o(rd_addr_o)
    );

    tlm_byte_out #(.DW(8)) u_out (
        .clk(clk), .rst(rst), .req_valid_i(req_valid), .mark_i(req_mark),
        .rd_data_i(rd_data_i), .byte_valid_o(byte_valid_o), .byte_o(byte_o),
        .mark_o(out_mark)
    );

    assign rd_en_o     = req_valid;
    assign minor_sop_o = out_mark.minor_sop;
    assign major_sop_o = out_mark.major_sop;

    AST_MINOR_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(minor_idx_o) |-> (minor_idx_o == '0 || minor_idx_o == $past(minor_idx_o) + 1'b1)); // R5

endmodule

// File: tb/tlm_commutator_tb.sv
`timescale 1ns/1ps
module tlm_commutator_tb;

    localparam int TPM = 5, BPT = 2, MPM = 3, SSTD = 1, SSAFE = 2, AW = 6;
    localparam int SLOTS = TPM * BPT;
    localparam int SW = $clog2(SLOTS + 1);
    localparam int MW = $clog2(MPM);

    logic clk = 0, rst = 1, tick_i = 0, tw_en_i = 0;
    logic [1:0] rate_req_i = 2'd2;
    logic [SW-1:0] tw_idx_i = '0;
    logic [AW-1:0] tw_src_i = '0;
    logic rd_en_o, byte_valid_o, minor_sop_o, major_sop_o;
    logic [AW-1:0] rd_addr_o;
    logic [7:0] rd_data_i = '0, byte_o;
    logic [MW-1:0] minor_idx_o;

    always #4 clk = ~clk;

    tlm_commutator #(.TPM(TPM), .BPT(BPT), .MPM(MPM), .STD_SHIFT(SSTD),
                     .SAFE_SHIFT(SSAFE), .AW(AW)) u_dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .rate_req_i(rate_req_i),
        .tw_en_i(tw_en_i), .tw_idx_i(tw_idx_i), .tw_src_i(tw_src_i),
        .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
        .byte_valid_o(byte_valid_o), .byte_o(byte_o), .minor_sop_o(minor_sop_o),
        .major_sop_o(major_sop_o), .minor_idx_o(minor_idx_o));

    int n_chk = 0, n_err = 0;
    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pval(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    // Parameter source: one-cycle read latency
    always @(posedge clk) if (rd_en_o) rd_data_i <= pval(int'(rd_addr_o));

    // Bench model of the frame walk
    int sh[SLOTS], ac[SLOTS];
    int m_tp = 0, m_minor = 0, m_cur = 0, m_rate = 2, m_base = 0, tick_cnt = 0;
    int q_byte[$], q_mn[$], q_mj[$], q_idx[$], q_cnt[$];
    string q_tag[$];
    string tag = "R2";

    // Stream monitor
    bit mon_on = 0, seen_any = 0;
    int seen_cnt = 0, last_sop_tick = 0;
    always @(negedge clk) if (mon_on) begin
        if (byte_valid_o) begin
            if (minor_sop_o) begin
                if (seen_any) begin
                    if (q_cnt.size() > 0) begin
                        check(seen_cnt == q_cnt[0], "R3", "bytes per minor frame", seen_cnt, q_cnt[0]);
                        void'(q_cnt.pop_front());
                    end
                    check(tick_cnt - last_sop_tick == TPM, "R10", "ticks between minor starts",
                          tick_cnt - last_sop_tick, TPM);
                end
                seen_any = 1; seen_cnt = 0; last_sop_tick = tick_cnt;
            end
            seen_cnt++;
            if (q_byte.size() == 0) begin
                check(0, "R2", "byte with nothing expected", int'(byte_o), -1);
            end else begin
                check(byte_o == q_byte[0], q_tag[0], "byte value", int'(byte_o), q_byte[0]);
                check(minor_sop_o == q_mn[0], "R4", "minor start flag", int'(minor_sop_o), q_mn[0]);
                check(major_sop_o == q_mj[0], "R4", "major start flag", int'(major_sop_o), q_mj[0]);
                check(minor_idx_o == q_idx[0], "R5", "minor index", int'(minor_idx_o), q_idx[0]);
                void'(q_byte.pop_front()); void'(q_mn.pop_front()); void'(q_mj.pop_front());
                void'(q_idx.pop_front()); void'(q_tag.pop_front());
            end
        end else if (minor_sop_o || major_sop_o) begin
            check(0, "R4", "frame flag without byte", 1, 0);
        end
    end

    task automatic do_tick();
        bit at_minor, at_major, fire;
        int mask, got, cnt;
        int exp_a[BPT];
        at_minor = (m_tp == 0);
        at_major = at_minor && (m_minor == 0);
        if (at_major && rate_req_i != 2'd3) m_rate = int'(rate_req_i);
        mask = (m_rate == 2) ? 0 : (m_rate == 1) ? (1 << SSTD) - 1 : (1 << SSAFE) - 1;
        if (at_minor) begin
            for (int i = 0; i < SLOTS; i++) ac[i] = sh[i];
            m_cur = m_minor; m_base = 0;
            cnt = 0;
            for (int t = 0; t < TPM; t++) if ((t & mask) == 0) cnt += BPT;
            q_cnt.push_back(cnt);
        end
        fire = ((m_tp & mask) == 0);
        if (fire) begin
            for (int b = 0; b < BPT; b++) begin
                exp_a[b] = ac[m_base + b];
                q_byte.push_back(int'(pval(exp_a[b])));
                q_mn.push_back((at_minor && b == 0) ? 1 : 0);
                q_mj.push_back((at_major && b == 0) ? 1 : 0);
                q_idx.push_back(m_cur);
                q_tag.push_back(tag);
            end
            m_base += BPT;
        end
        if (m_tp == TPM - 1) begin
            m_tp = 0; m_minor = (m_minor == MPM - 1) ? 0 : m_minor + 1;
        end else m_tp++;
        @(negedge clk); tick_i = 1; tick_cnt++;
        @(negedge clk); tick_i = 0;
        got = 0;
        for (int c = 0; c < 7; c++) begin
            if (rd_en_o) begin
                if (got < BPT)
                    check(rd_addr_o == AW'(exp_a[got]), "R6", "read address from live table",
                          int'(rd_addr_o), exp_a[got]);
                got++;
            end
            @(negedge clk);
        end
        check(got == (fire ? BPT : 0), "R9", "read strobes per tick", got, fire ? BPT : 0);
    endtask

    task automatic tab_write(int idx, int src);
        @(negedge clk); tw_en_i = 1; tw_idx_i = SW'(idx); tw_src_i = AW'(src);
        @(negedge clk); tw_en_i = 0;
        sh[idx] = src;
    endtask

    initial begin
        for (int i = 0; i < SLOTS; i++) begin sh[i] = 0; ac[i] = 0; end
        repeat (4) @(negedge clk);
        check(byte_valid_o == 0 && rd_en_o == 0, "R1", "outputs idle in reset", int'(byte_valid_o), 0);
        rst = 0;
        @(negedge clk);
        check(minor_idx_o == 0, "R1", "minor index after reset", int'(minor_idx_o), 0);
        check(!minor_sop_o && !major_sop_o, "R1", "frame flags after reset", int'(minor_sop_o), 0);
        mon_on = 1;
        for (int i = 0; i < SLOTS; i++) tab_write(i, (i * 3 + 1) % 64);
        repeat (5) @(negedge clk);
        check(byte_valid_o == 0 && rd_en_o == 0, "R1", "no output before first tick", int'(byte_valid_o), 0);

        rate_req_i = 2'd2;
        tag = "R2"; for (int k = 0; k < 15; k++) do_tick();
        tag = "R5"; for (int k = 0; k < 3; k++) do_tick();
        rate_req_i = 2'd1;
        tag = "R7"; for (int k = 0; k < 12; k++) do_tick();
        tag = "R3"; for (int k = 0; k < 2; k++) do_tick();
        tab_write(0, 50);
        tab_write(2, 40);
        tag = "R6"; for (int k = 0; k < 8; k++) do_tick();
        rate_req_i = 2'd0;
        tag = "R7"; for (int k = 0; k < 5; k++) do_tick();
        tag = "R3"; for (int k = 0; k < 5; k++) do_tick();
        rate_req_i = 2'd3;
        tag = "R8"; for (int k = 0; k < 15; k++) do_tick();
        rate_req_i = 2'd2;
        tag = "R7"; for (int k = 0; k < 15; k++) do_tick();
        repeat (10) @(negedge clk);
        check(q_byte.size() == 0, "R2", "expected bytes left unseen", q_byte.size(), 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule